// File: doc/BRIEF.md
# Banked Address Decoder with Control Registers

This block sits on the bus of an 8-bit processor with a 16-bit address space. It sorts every bus address into one of four regions and raises exactly one select: a 16k window into a 32k work RAM, a block of I/O registers, a flat 32k video RAM, or an 8k window into a 32k EEPROM. For the two windowed memories it extends the address with page bits taken from a hardware control register. That register also carries a display bank bit and a video mode bit, and both leave the block as plain outputs.

Inside the I/O region the block implements the control register itself. It also provides an index/data pair that reaches the registers of an external CRT timing controller, and six read-only keyboard row ports. A keyboard row is sampled through a two-stage synchroniser before the read multiplexer sees it. The memories, the CRT controller and the keyboard scanning circuit are outside this block.

The processor bus is a single-cycle strobe bus with no back-pressure. The block therefore uses no valid/ready handshake. Decoding and read data are combinational from the address. A register write takes effect at the rising clock edge on which `cpu_we` is high.

Top module: `banked_addr_decoder`

## Requirements
- R1: Exactly one select is high for every address. `ram_cs` is high for 0x0000–0x3FFF, `io_cs` for 0x4000–0x5FFF, `vram_cs` for 0x6000–0xDFFF and `rom_cs` for 0xE000–0xFFFF.
- R2: `ram_addr` is {control bit 5, cpu_addr[13:0]}. Control bit 5 is the RAM page bit.
- R3: `rom_addr` is {control bits 7:6, cpu_addr[12:0]}. Bit 7 is the ROM page MSB and bit 6 is the ROM page LSB.
- R4: `vram_addr` is cpu_addr minus 0x6000, truncated to 15 bits.
- R5: A write to 0x4000 loads control bits 7:3. A read of 0x4000 returns those bits with bits 2:0 forced to zero. `bank_page` equals control bit 4. `video_mode` equals control bit 3, where 1 means high-resolution.
- R6: Reset clears the control register and the CRT index to zero. After reset, `video_mode`, `bank_page`, `crt_index` and a read of 0x4000 are all zero.
- R7: A write to 0x4200 loads `crt_index` from cpu_wdata[4:0]. A write to 0x4201 raises `crt_wr` for that cycle, with `crt_wdata` equal to `cpu_wdata`.
- R8: A read strobe at 0x4201 raises `crt_rd`. The read data is `crt_rdata` when `crt_index` is between 14 and 17 inclusive, and zero for any other index.
- R9: A read of 0x4400+r, for r from 0 to 5, returns keyboard row r (bits [8r+7:8r] of `kbd_rows`, where 1 means pressed). An input change becomes visible after the second rising edge that follows it. Row 5 always reads bits 4:0 as zero.
- R10: Writes to the keyboard ports, to 0x4201 and to any memory region leave the control register unchanged. A read of any I/O address not named above returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data from the I/O region, zero elsewhere |
| ram_cs | output | 1 | Work RAM select |
| io_cs | output | 1 | I/O region select |
| vram_cs | output | 1 | Video RAM select |
| rom_cs | output | 1 | EEPROM select |
| ram_addr | output | 15 | Physical work RAM address |
| vram_addr | output | 15 | Physical video RAM address |
| rom_addr | output | 15 | Physical EEPROM address |
| bank_page | output | 1 | Display bank page bit |
| video_mode | output | 1 | 0 means character mode, 1 means high-resolution |
| crt_index | output | 5 | Selected CRT controller register |
| crt_wr | output | 1 | CRT register write strobe |
| crt_rd | output | 1 | CRT register read strobe |
| crt_wdata | output | 8 | CRT register write data |
| crt_rdata | input | 8 | CRT register read data |
| kbd_rows | input | 48 | Raw keyboard rows, row r in bits [8r+7:8r] |

## Verification
A corrupted control register shows up on the cycle after the bad write. It appears in the upper bit of `ram_addr` or the upper two bits of `rom_addr`, and also on `bank_page`, `video_mode` and a read of 0x4000. A stale or wrong CRT index shows on `crt_index` right away, and gates `crt_rdata` onto the bus or masks it. A synchroniser with the wrong depth makes a key appear one edge early or one edge late. The bench checks for this by sampling the same row after each edge.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_VRAM = 2'd2,
    RGN_ROM  = 2'd3
  } region_e;

  localparam logic [15:0] IO_BASE   = 16'h4000;
  localparam logic [15:0] VRAM_BASE = 16'h6000;
  localparam logic [15:0] ROM_BASE  = 16'hE000;

  localparam logic [15:0] CTL_ADDR  = 16'h4000;
  localparam logic [15:0] CRT_IDX_A = 16'h4200;
  localparam logic [15:0] CRT_DAT_A = 16'h4201;
  localparam logic [15:0] KBD_BASE  = 16'h4400;

  localparam int CTL_ROM_HI = 7;
  localparam int CTL_ROM_LO = 6;
  localparam int CTL_RAM    = 5;
  localparam int CTL_BANK   = 4;
  localparam int CTL_VMODE  = 3;
  localparam logic [7:0] CTL_WMASK = 8'hF8;
endpackage

// File: rtl/bdec_region.sv
module bdec_region
  import bdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 15
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              ram_page,
  input  logic [1:0]        rom_page,
  output region_e           region,
  output logic              ram_cs,
  output logic              io_cs,
  output logic              vram_cs,
  output logic              rom_cs,
  output logic [PHYS_W-1:0] ram_addr,
  output logic [PHYS_W-1:0] vram_addr,
  output logic [PHYS_W-1:0] rom_addr
);
  localparam int RAM_WIN_W = PHYS_W - 1;
  localparam int ROM_WIN_W = PHYS_W - 2;

  logic [ADDR_W-1:0] vram_off;

  always_comb begin
    if (cpu_addr < IO_BASE)        region = RGN_RAM;
    else if (cpu_addr < VRAM_BASE) region = RGN_IO;
    else if (cpu_addr < ROM_BASE)  region = RGN_VRAM;
    else                           region = RGN_ROM;
  end

  assign ram_cs  = (region == RGN_RAM);
  assign io_cs   = (region == RGN_IO);
  assign vram_cs = (region == RGN_VRAM);
  assign rom_cs  = (region == RGN_ROM);

  assign vram_off  = cpu_addr - VRAM_BASE;
  assign ram_addr  = {ram_page, cpu_addr[RAM_WIN_W-1:0]};
  assign rom_addr  = {rom_page, cpu_addr[ROM_WIN_W-1:0]};
  assign vram_addr = vram_off[PHYS_W-1:0];
endmodule

// File: rtl/bdec_regs.sv
module bdec_regs
  import bdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_cs,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [IDX_W-1:0]  crt_idx_q
);
  logic ctl_wr, idx_wr;

  assign ctl_wr = io_cs && cpu_we && (cpu_addr == CTL_ADDR);
  assign idx_wr = io_cs && cpu_we && (cpu_addr == CRT_IDX_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      crt_idx_q <= '0;
    end else begin
      if (ctl_wr) ctrl_q <= cpu_wdata & CTL_WMASK;
      if (idx_wr) crt_idx_q <= cpu_wdata[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/bdec_kbd_sync.sv
module bdec_kbd_sync #(
  parameter int         ROWS      = 6,
  parameter int         STAGES    = 2,
  parameter logic [7:0] LAST_MASK = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROWS*8-1:0] raw_rows,
  output logic [ROWS*8-1:0] sync_rows
);
  localparam int W = ROWS * 8;

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= raw_rows;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == ROWS - 1) begin : g_last
      assign sync_rows[r*8 +: 8] = stage_q[STAGES-1][r*8 +: 8] & LAST_MASK;
    end else begin : g_full
      assign sync_rows[r*8 +: 8] = stage_q[STAGES-1][r*8 +: 8];
    end
  end
endmodule

// File: rtl/bdec_rdmux.sv
module bdec_rdmux
  import bdec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 5,
  parameter int ROWS    = 6,
  parameter int CRT_RLO = 14,
  parameter int CRT_RHI = 17
) (
  input  logic              io_cs,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [IDX_W-1:0]  crt_idx,
  input  logic [DATA_W-1:0] crt_rdata,
  input  logic [ROWS*8-1:0] kbd_rows,
  output logic [DATA_W-1:0] io_rdata
);
  logic crt_readable;

  assign crt_readable = (crt_idx >= IDX_W'(CRT_RLO)) && (crt_idx <= IDX_W'(CRT_RHI));

  always_comb begin
    io_rdata = '0;
    if (io_cs) begin
      if (cpu_addr == CTL_ADDR) begin
        io_rdata = ctrl_q;
      end else if (cpu_addr == CRT_DAT_A) begin
        if (crt_readable) io_rdata = crt_rdata;
      end else begin
        for (int r = 0; r < ROWS; r++) begin
          if (cpu_addr == KBD_BASE + ADDR_W'(r)) io_rdata = kbd_rows[r*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/banked_addr_decoder.sv
module banked_addr_decoder
  import bdec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PHYS_W     = 15,
  parameter int IDX_W      = 5,
  parameter int KBD_ROWS   = 6,
  parameter int SYNC_STAGE = 2,
  parameter int CRT_RLO    = 14,
  parameter int CRT_RHI    = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                cpu_we,
  input  logic                cpu_re,
  output logic [DATA_W-1:0]   io_rdata,
  output logic                ram_cs,
  output logic                io_cs,
  output logic                vram_cs,
  output logic                rom_cs,
  output logic [PHYS_W-1:0]   ram_addr,
  output logic [PHYS_W-1:0]   vram_addr,
  output logic [PHYS_W-1:0]   rom_addr,
  output logic                bank_page,
  output logic                video_mode,
  output logic [IDX_W-1:0]    crt_index,
  output logic                crt_wr,
  output logic                crt_rd,
  output logic [DATA_W-1:0]   crt_wdata,
  input  logic [DATA_W-1:0]   crt_rdata,
  input  logic [KBD_ROWS*8-1:0] kbd_rows
);
  localparam int KW = KBD_ROWS * 8;

  region_e           region;
  logic [DATA_W-1:0] ctrl_q;
  logic [KW-1:0]     kbd_sync;
  logic              crt_dat_hit;

  bdec_region #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_region (
    .cpu_addr (cpu_addr),
    .ram_page (ctrl_q[CTL_RAM]),
    .rom_page (ctrl_q[CTL_ROM_HI:CTL_ROM_LO]),
    .region   (region),
    .ram_cs   (ram_cs),
    .io_cs    (io_cs),
    .vram_cs  (vram_cs),
    .rom_cs   (rom_cs),
    .ram_addr (ram_addr),
    .vram_addr(vram_addr),
    .rom_addr (rom_addr)
  );

  bdec_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_cs    (io_cs),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_we   (cpu_we),
    .ctrl_q   (ctrl_q),
    .crt_idx_q(crt_index)
  );

  bdec_kbd_sync #(.ROWS(KBD_ROWS), .STAGES(SYNC_STAGE), .LAST_MASK(8'hE0)) u_kbd (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_rows (kbd_rows),
    .sync_rows(kbd_sync)
  );

  bdec_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .ROWS(KBD_ROWS), .CRT_RLO(CRT_RLO), .CRT_RHI(CRT_RHI)
  ) u_rdmux (
    .io_cs    (io_cs),
    .cpu_addr (cpu_addr),
    .ctrl_q   (ctrl_q),
    .crt_idx  (crt_index),
    .crt_rdata(crt_rdata),
    .kbd_rows (kbd_sync),
    .io_rdata (io_rdata)
  );

  assign crt_dat_hit = io_cs && (cpu_addr == CRT_DAT_A);
  assign crt_wr      = crt_dat_hit && cpu_we;
  assign crt_rd      = crt_dat_hit && cpu_re;
  assign crt_wdata   = cpu_wdata;
  assign bank_page   = ctrl_q[CTL_BANK];
  assign video_mode  = ctrl_q[CTL_VMODE];
endmodule

// File: rtl/bdec_checker.sv
module bdec_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PHYS_W = 15,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_we,
  input logic              ram_cs,
  input logic              io_cs,
  input logic              vram_cs,
  input logic              rom_cs,
  input logic [PHYS_W-1:0] ram_addr,
  input logic [PHYS_W-1:0] vram_addr,
  input logic [PHYS_W-1:0] rom_addr,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [IDX_W-1:0]  crt_index,
  input logic              crt_wr,
  input logic [DATA_W-1:0] io_rdata
);
  logic ctl_write;
  assign ctl_write = cpu_we && (cpu_addr == 16'h4000);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_cs, io_cs, vram_cs, rom_cs}) == 1); // R1
  AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> (ram_addr[13:0] == cpu_addr[13:0]) && (ram_addr[14] == ctrl_q[5])); // R2
  AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> (rom_addr[12:0] == cpu_addr[12:0]) && (rom_addr[14:13] == ctrl_q[7:6])); // R3
  AST_VRAM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    vram_cs |-> (vram_addr[12:0] == cpu_addr[12:0])); // R4
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write |=> (ctrl_q[7:3] == $past(cpu_wdata[7:3])) && (ctrl_q[2:0] == 3'b000)); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_q == '0) && (crt_index == '0)); // R6
  AST_CRT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    crt_wr |-> (cpu_addr == 16'h4201) && cpu_we); // R7
  AST_CRT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_addr == 16'h4201) && ((crt_index < 5'd14) || (crt_index > 5'd17))) |-> (io_rdata == '0)); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_write |=> $stable(ctrl_q)); // R10
endmodule

bind banked_addr_decoder bdec_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHYS_W(PHYS_W), .IDX_W(IDX_W)
) u_bdec_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_addr (cpu_addr),
  .cpu_wdata(cpu_wdata),
  .cpu_we   (cpu_we),
  .ram_cs   (ram_cs),
  .io_cs    (io_cs),
  .vram_cs  (vram_cs),
  .rom_cs   (rom_cs),
  .ram_addr (ram_addr),
  .vram_addr(vram_addr),
  .rom_addr (rom_addr),
  .ctrl_q   (ctrl_q),
  .crt_index(crt_index),
  .crt_wr   (crt_wr),
  .io_rdata (io_rdata)
);

// File: tb/test_banked_addr_decoder.sv
module test_banked_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_re = 1'b0;
  logic [7:0]  io_rdata;
  logic        ram_cs, io_cs, vram_cs, rom_cs;
  logic [14:0] ram_addr, vram_addr, rom_addr;
  logic        bank_page, video_mode;
  logic [4:0]  crt_index;
  logic        crt_wr, crt_rd;
  logic [7:0]  crt_wdata;
  logic [7:0]  crt_rdata = '0;
  logic [47:0] kbd_rows = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  banked_addr_decoder i_banked_addr_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .io_rdata(io_rdata),
    .ram_cs(ram_cs), .io_cs(io_cs), .vram_cs(vram_cs), .rom_cs(rom_cs),
    .ram_addr(ram_addr), .vram_addr(vram_addr), .rom_addr(rom_addr),
    .bank_page(bank_page), .video_mode(video_mode), .crt_index(crt_index),
    .crt_wr(crt_wr), .crt_rd(crt_rd), .crt_wdata(crt_wdata),
    .crt_rdata(crt_rdata), .kbd_rows(kbd_rows)
  );

  // {ctrl value, address, {ram,io,vram,rom} selects, expected physical address}
  localparam logic [42:0] VEC [13] = '{
    {8'h00, 16'h0000, 4'b1000, 15'h0000},
    {8'h20, 16'h3FFF, 4'b1000, 15'h7FFF},
    {8'h00, 16'h1234, 4'b1000, 15'h1234},
    {8'h20, 16'h2000, 4'b1000, 15'h6000},
    {8'h00, 16'h4000, 4'b0100, 15'h0000},
    {8'h00, 16'h5FFF, 4'b0100, 15'h0000},
    {8'h00, 16'h6000, 4'b0010, 15'h0000},
    {8'h00, 16'hDFFF, 4'b0010, 15'h7FFF},
    {8'h00, 16'h9ABC, 4'b0010, 15'h3ABC},
    {8'h00, 16'hE000, 4'b0001, 15'h0000},
    {8'hC0, 16'hFFFF, 4'b0001, 15'h7FFF},
    {8'h40, 16'hE123, 4'b0001, 15'h2123},
    {8'h80, 16'hF0F0, 4'b0001, 15'h50F0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; cpu_re = 1'b0;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b0; cpu_re = 1'b1;
    #5;
  endtask

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset state
    bus_read(16'h4000);
    check("R6 ctrl read", io_rdata, 8'h00);
    check("R6 video_mode", video_mode, 1'b0);
    check("R6 bank_page", bank_page, 1'b0);
    check("R6 crt_index", crt_index, 5'd0);

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < 13; i++) begin
      logic [7:0]  c;
      logic [15:0] a;
      logic [3:0]  cs;
      logic [14:0] ph;
      {c, a, cs, ph} = VEC[i];
      bus_write(16'h4000, c);
      bus_read(a);
      check("R1 selects", {ram_cs, io_cs, vram_cs, rom_cs}, cs);
      if (cs[3]) check("R2 ram_addr", ram_addr, ph);
      if (cs[1]) check("R4 vram_addr", vram_addr, ph);
      if (cs[0]) check("R3 rom_addr", rom_addr, ph);
    end

    // R5: control write and readback
    bus_write(16'h4000, 8'hFF);
    bus_read(16'h4000);
    check("R5 ctrl readback", io_rdata, 8'hF8);
    check("R5 video_mode", video_mode, 1'b1);
    check("R5 bank_page", bank_page, 1'b1);
    bus_write(16'h4000, 8'h08);
    bus_read(16'h4000);
    check("R5 bank off", bank_page, 1'b0);
    check("R5 mode on", video_mode, 1'b1);

    // R10: writes elsewhere leave control unchanged
    bus_write(16'h1000, 8'hFF);
    bus_write(16'h4402, 8'hFF);
    bus_write(16'h4201, 8'hFF);
    bus_write(16'hE000, 8'hFF);
    bus_read(16'h4000);
    check("R10 ctrl kept", io_rdata, 8'h08);
    bus_read(16'h4300);
    check("R10 unmapped io", io_rdata, 8'h00);
    bus_read(16'h4406);
    check("R10 past last row", io_rdata, 8'h00);

    // R7: index latch and data write strobe
    bus_write(16'h4200, 8'hEE);
    @(negedge clk);
    check("R7 crt_index", crt_index, 5'h0E);
    cpu_addr = 16'h4201; cpu_wdata = 8'h50; cpu_we = 1'b1;
    #5;
    check("R7 crt_wr", crt_wr, 1'b1);
    check("R7 crt_wdata", crt_wdata, 8'h50);
    @(negedge clk);
    cpu_we = 1'b0;
    #5;
    check("R7 crt_wr low", crt_wr, 1'b0);

    // R8: readable range and masking
    crt_rdata = 8'h5A;
    bus_read(16'h4201);
    check("R8 crt_rd", crt_rd, 1'b1);
    check("R8 idx14 data", io_rdata, 8'h5A);
    bus_write(16'h4200, 8'h11);
    bus_read(16'h4201);
    check("R8 idx17 data", io_rdata, 8'h5A);
    bus_write(16'h4200, 8'h0D);
    bus_read(16'h4201);
    check("R8 idx13 masked", io_rdata, 8'h00);
    bus_write(16'h4200, 8'h12);
    bus_read(16'h4201);
    check("R8 idx18 masked", io_rdata, 8'h00);

    // R9: keyboard rows through two-stage synchroniser
    @(negedge clk);
    kbd_rows = 48'hFF_44_33_22_11_A5;
    cpu_addr = 16'h4400; cpu_re = 1'b1;
    #5;
    check("R9 row0 before edge", io_rdata, 8'h00);
    @(posedge clk); #5;
    check("R9 row0 after one edge", io_rdata, 8'h00);
    @(posedge clk); #5;
    check("R9 row0 after two edges", io_rdata, 8'hA5);
    bus_read(16'h4403);
    check("R9 row3", io_rdata, 8'h33);
    bus_read(16'h4405);
    check("R9 row5 masked", io_rdata, 8'hE0);
    bus_write(16'h4403, 8'h00);
    bus_read(16'h4403);
    check("R10 kbd write ignored", io_rdata, 8'h33);

    // R6: reset again after activity
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(16'h4000);
    check("R6 ctrl after reset", io_rdata, 8'h00);
    check("R6 index after reset", crt_index, 5'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule